// File: doc/BRIEF.md
# FSK Tag Waveform Encoder

This block turns a 44-bit identifier into an endless one-bit waveform for a low-frequency tag emulator. It emits one sample per enabled sample-clock tick. Each waveform element is a burst of one of two carrier shapes. The short shape is a period of 8 samples, repeated to 48 samples. The long shape is a period of 10 samples, repeated to 50 samples.

A frame opens with a fixed marker built from eight bursts. That marker is not valid Manchester code. The identifier then follows, most significant bit first. Each bit is a pair of bursts, and an extra short burst is placed at the head of every group of four bits. Frames follow one another without a gap until a stop request is honoured at a frame boundary.

A controller presents the identifier on `id_i` and pulses `start`. The coil driver consumes `sample` on every cycle where `tick` is high. `frame_start` marks the first sample of every frame.

Top module: `fsk_tag_encoder`

## Requirements
- R1: After synchronous reset, `sample`, `frame_start` and `load_err` are all 0 and the encoder is idle.
- R2: A short burst is 6 repeats of an 8-sample period, where the first 2 samples of each period are 1 and the other 6 are 0.
- R3: A long burst is 5 repeats of a 10-sample period, where the first 3 samples of each period are 1 and the other 7 are 0.
- R4: Every frame begins with the marker bursts short, short, short, long, long, long, short, long, in that order.
- R5: The identifier is sent from bit 43 down to bit 0. A 1 is sent as a long burst then a short burst. A 0 is sent as a short burst then a long burst.
- R6: One extra short burst comes directly before each bit whose index modulo 4 is 3 (bits 43, 39, …, 3), ahead of that bit's two bursts.
- R7: After bit 0 the next frame starts at once with the marker. `frame_start` is 1 only on the tick that consumes the first marker sample of a frame.
- R8: A `start` while idle with any of `id_i[47:44]` set is rejected. In that case `load_err` is 1 for exactly the following cycle, and `sample` stays 0.
- R9: A `stop` while running ends output after the last sample of the current frame, including a `stop` on that very sample's tick. After that, `sample` stays 0.
- R10: State advances only on cycles with `tick` high. Between ticks, `sample` holds the value that has not yet been consumed.
- R11: A `start` while running does not reload the identifier. A `stop` while idle is not remembered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable; the current sample is consumed on this cycle |
| start | input | 1 | Load request; takes effect only when idle |
| stop | input | 1 | End request; honoured at the next frame boundary |
| id_i | input | 48 | Identifier; bits 43:0 are sent, bits 47:44 must be 0 |
| sample | output | 1 | Waveform sample |
| frame_start | output | 1 | High on the tick that consumes the first sample of a frame |
| load_err | output | 1 | One-cycle pulse after a rejected load |

## Verification
The stop request and the frame wrap can fall in the same cycle. The bench provokes this by asserting `stop` on exactly the tick that consumes the final sample of the second frame. The scoreboard then expects the waveform to end there, and it flags any extra marker sample or `frame_start` pulse as a failure. Two other overlaps are also covered. A `start` is pulsed mid-frame with a different identifier, and the waveform must not change. A stop request is left pending while `tick` is gated at random.

// File: rtl/fsk_enc_pkg.sv
package fsk_enc_pkg;
    localparam int ID_BITS    = 44;
    localparam int LOAD_BITS  = 48;
    localparam int SHORT_PER  = 8;
    localparam int SHORT_HI   = 2;
    localparam int SHORT_REPS = 6;
    localparam int LONG_PER   = 10;
    localparam int LONG_HI    = 3;
    localparam int LONG_REPS  = 5;
    localparam int MARK_LEN   = 8;
    // bit k set: marker burst k is long
    localparam logic [MARK_LEN-1:0] MARK_MAP = 8'b1011_1000;
    localparam int GROUP      = 4;

    typedef enum logic {BK_SHORT = 1'b0, BK_LONG = 1'b1} burst_kind_e;
    typedef enum logic [1:0] {SQ_MARK, SQ_PAD, SQ_HALF0, SQ_HALF1} seq_st_e;

    // kind of the burst for a data bit; second selects the trailing half
    function automatic burst_kind_e half_kind(logic bit_v, logic second);
        return (bit_v ^ second) ? BK_LONG : BK_SHORT;
    endfunction
endpackage

// File: rtl/fsk_burst_gen.sv
module fsk_burst_gen
    import fsk_enc_pkg::*;
#(
    parameter int S_PER  = SHORT_PER,
    parameter int S_HI   = SHORT_HI,
    parameter int S_REPS = SHORT_REPS,
    parameter int L_PER  = LONG_PER,
    parameter int L_HI   = LONG_HI,
    parameter int L_REPS = LONG_REPS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        adv,
    input  burst_kind_e kind,
    output logic        level,
    output logic        burst_last,
    output logic        at_start
);
    localparam int MAX_PER  = (S_PER > L_PER) ? S_PER : L_PER;
    localparam int MAX_REPS = (S_REPS > L_REPS) ? S_REPS : L_REPS;
    localparam int PW = $clog2(MAX_PER + 1);
    localparam int RW = $clog2(MAX_REPS + 1);

    logic [PW-1:0] pos, per_m1, hi_n;
    logic [RW-1:0] rep, rep_m1;
    logic          last_pos;

    always_comb begin
        if (kind == BK_LONG) begin
            per_m1 = PW'(L_PER - 1);
            hi_n   = PW'(L_HI);
            rep_m1 = RW'(L_REPS - 1);
        end else begin
            per_m1 = PW'(S_PER - 1);
            hi_n   = PW'(S_HI);
            rep_m1 = RW'(S_REPS - 1);
        end
        level      = (pos < hi_n);
        last_pos   = (pos == per_m1);
        burst_last = last_pos && (rep == rep_m1);
        at_start   = (pos == '0) && (rep == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos <= '0;
            rep <= '0;
        end else if (adv) begin
            if (last_pos) begin
                pos <= '0;
                rep <= burst_last ? '0 : rep + RW'(1);
            end else begin
                pos <= pos + PW'(1);
            end
        end
    end

    // R2 R3: the burst shape from the sequencer stays fixed inside a burst
    p_kind_steady_r2: assert property (@(posedge clk) disable iff (rst || clear)
        !(adv && burst_last) |=> $stable(kind));
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
    import fsk_enc_pkg::*;
#(
    parameter int ID_W  = ID_BITS,
    parameter int MLEN  = MARK_LEN,
    parameter logic [MLEN-1:0] MMAP = MARK_MAP,
    parameter int GRP   = GROUP
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            adv,
    input  logic [ID_W-1:0] id,
    output burst_kind_e     kind,
    output logic            frame_first,
    output logic            frame_last
);
    localparam int BW = $clog2(ID_W);
    localparam int SW = $clog2(MLEN);

    seq_st_e       st;
    logic [SW-1:0] mk_idx;
    logic [BW-1:0] bit_idx, nxt_bit;

    function automatic logic pad_needed(logic [BW-1:0] b);
        return (int'(b) % GRP) == (GRP - 1);
    endfunction

    always_comb begin
        nxt_bit = bit_idx - BW'(1);
        unique case (st)
            SQ_MARK:  kind = MMAP[mk_idx] ? BK_LONG : BK_SHORT;
            SQ_PAD:   kind = BK_SHORT;
            SQ_HALF0: kind = half_kind(id[bit_idx], 1'b0);
            default:  kind = half_kind(id[bit_idx], 1'b1);
        endcase
        frame_first = (st == SQ_MARK) && (mk_idx == '0);
        frame_last  = (st == SQ_HALF1) && (bit_idx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st      <= SQ_MARK;
            mk_idx  <= '0;
            bit_idx <= '0;
        end else if (adv) begin
            unique case (st)
                SQ_MARK: begin
                    if (mk_idx == SW'(MLEN - 1)) begin
                        mk_idx  <= '0;
                        bit_idx <= BW'(ID_W - 1);
                        st      <= pad_needed(BW'(ID_W - 1)) ? SQ_PAD : SQ_HALF0;
                    end else begin
                        mk_idx <= mk_idx + SW'(1);
                    end
                end
                SQ_PAD:   st <= SQ_HALF0;
                SQ_HALF0: st <= SQ_HALF1;
                default: begin
                    if (bit_idx == '0) begin
                        st <= SQ_MARK;
                    end else begin
                        bit_idx <= nxt_bit;
                        st      <= pad_needed(nxt_bit) ? SQ_PAD : SQ_HALF0;
                    end
                end
            endcase
        end
    end

    // R7: the last data burst is always followed by the first marker burst
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst || clear)
        (adv && frame_last) |=> frame_first);
endmodule

// File: rtl/fsk_tag_encoder.sv
module fsk_tag_encoder
    import fsk_enc_pkg::*;
#(
    parameter int ID_W   = ID_BITS,
    parameter int LOAD_W = LOAD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              stop,
    input  logic [LOAD_W-1:0] id_i,
    output logic              sample,
    output logic              frame_start,
    output logic              load_err
);
    logic            running, stop_pend;
    logic [ID_W-1:0] id_q;
    logic            id_ok, accept, reject, adv, adv_burst, fr_end;
    logic            level, burst_last, at_start, frame_first, frame_last;
    burst_kind_e     kind;

    assign id_ok     = ~|id_i[LOAD_W-1:ID_W];
    assign accept    = start && !running && id_ok;
    assign reject    = start && !running && !id_ok;
    assign adv       = running && tick;
    assign adv_burst = adv && burst_last;
    assign fr_end    = adv_burst && frame_last;

    fsk_burst_gen u_burst (
        .clk(clk), .rst(rst), .clear(accept), .adv(adv), .kind(kind),
        .level(level), .burst_last(burst_last), .at_start(at_start)
    );

    fsk_frame_seq #(.ID_W(ID_W)) u_seq (
        .clk(clk), .rst(rst), .clear(accept), .adv(adv_burst), .id(id_q),
        .kind(kind), .frame_first(frame_first), .frame_last(frame_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
            id_q      <= '0;
            load_err  <= 1'b0;
        end else begin
            load_err <= reject;
            if (accept) begin
                running   <= 1'b1;
                stop_pend <= 1'b0;
                id_q      <= id_i[ID_W-1:0];
            end else if (running) begin
                if (fr_end && (stop_pend || stop)) begin
                    running   <= 1'b0;
                    stop_pend <= 1'b0;
                end else if (stop) begin
                    stop_pend <= 1'b1;
                end
            end
        end
    end

    assign sample      = running && level;
    assign frame_start = adv && frame_first && at_start;

    // R10: without a tick the waveform and run state hold
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (running && !tick) |=> (running && $stable(sample)));
    // R8: a rejected load leaves the output idle
    p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
        load_err |-> (!running && !sample));
    // R7: the first marker sample is always high
    p_fs_high_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> sample);
    // R9: running only ends on the final tick of a frame
    p_stop_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (running && !(tick && frame_last && burst_last)) |=> running);
endmodule

// File: tb/sim_fsk_tag_encoder.sv
module sim_fsk_tag_encoder;
    logic        clk = 1'b0;
    logic        rst, tick, start, stop;
    logic [47:0] id_i;
    logic        sample, frame_start, load_err;

    typedef struct { bit s; bit fs; int req; } exp_t;
    exp_t q[$];

    int  n_chk = 0, n_fail = 0;
    bit  armed = 1'b0, gap = 1'b0, done = 1'b0;
    logic [7:0] lf = 8'h5B;

    always #10 clk = ~clk;

    fsk_tag_encoder u0 (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .stop(stop),
        .id_i(id_i), .sample(sample), .frame_start(frame_start), .load_err(load_err)
    );

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // R2 R3: burst shapes
    task automatic push_burst(bit lng, int req, bit first);
        int per  = lng ? 10 : 8;
        int hi   = lng ? 3 : 2;
        int reps = lng ? 5 : 6;
        for (int r = 0; r < reps; r++)
            for (int p = 0; p < per; p++)
                q.push_back('{s: (p < hi), fs: (first && r == 0 && p == 0), req: req});
    endtask

    task automatic push_frame(logic [43:0] id);
        bit mark[8] = '{0, 0, 0, 1, 1, 1, 0, 1}; // R4 marker order
        for (int k = 0; k < 8; k++) push_burst(mark[k], 4, k == 0);
        for (int i = 43; i >= 0; i--) begin
            if (i % 4 == 3) push_burst(1'b0, 6, 1'b0);   // R6
            push_burst(id[i], 5, 1'b0);                  // R5
            push_burst(!id[i], 5, 1'b0);
        end
    endtask

    // tick pattern: every cycle, or gated pseudo-randomly
    always @(negedge clk) begin
        lf   <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        tick <= gap ? (lf[1:0] != 2'b00) : 1'b1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        #5;
        if (armed && !done) begin
            if (q.size() > 0) begin
                chk(sample == q[0].s, $sformatf("R%0d sample", tick ? q[0].req : 10),
                    sample, q[0].s);
                if (tick) begin
                    chk(frame_start == q[0].fs, "R7 frame_start", frame_start, q[0].fs);
                    void'(q.pop_front());
                end else begin
                    chk(frame_start == 1'b0, "R10 frame_start", frame_start, 0);
                end
            end else begin
                chk(sample == 1'b0 && frame_start == 1'b0, "R9 idle after stop",
                    {sample, frame_start}, 0);
            end
        end
    end

    task automatic run_case(logic [43:0] id, int nfr, bit gapm, bit stop_last, bit poke);
        gap = gapm;
        for (int f = 0; f < nfr; f++) push_frame(id);
        @(negedge clk);
        id_i  = {4'h0, id};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        armed = 1'b1;
        if (poke) begin                       // R11 start while running
            repeat (300) @(negedge clk);
            id_i  = 48'h0000_0F0F_1234;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (stop_last) begin                  // R9 stop on the final tick
            while (q.size() != 1) @(negedge clk);
        end else begin
            while (q.size() > 4000) @(negedge clk);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (30) @(negedge clk);
        armed = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; stop = 1'b0; id_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin     // R1
            @(negedge clk); #5;
            chk(sample == 0 && frame_start == 0 && load_err == 0, "R1 reset state",
                {sample, frame_start, load_err}, 0);
        end
        @(negedge clk);
        stop = 1'b1;                          // R11 stop while idle
        @(negedge clk);
        stop = 1'b0;
        id_i  = 48'h1000_0000_0000;           // R8 bit 44 set
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #5;
        chk(load_err == 1'b1, "R8 load_err pulse", load_err, 1);
        chk(sample == 1'b0, "R8 sample idle", sample, 0);
        @(negedge clk); #5;
        chk(load_err == 1'b0, "R8 load_err one cycle", load_err, 0);
        chk(sample == 1'b0, "R8 sample still idle", sample, 0);

        run_case(44'hB6D_1F08_C3A5, 2, 1'b0, 1'b1, 1'b1); // R9 R11 R7
        run_case(44'hFFF_FFFF_FFFF, 1, 1'b1, 1'b0, 1'b0); // R10 gated ticks
        run_case(44'h000_0000_0000, 1, 1'b0, 1'b0, 1'b0); // R5 all zero
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule